// File: doc/BRIEF.md
# Byte-Wide Memory Adapter over a Single-Bit Page-Mode DRAM

This controller lets a byte-oriented processor bus use one 256K x 1 dynamic RAM as a 32K x 8 memory. The byte address is widened by three bits to form a bit address. Each byte access opens the DRAM row once. It then runs eight page-mode column cycles, one per bit, while the processor is held in wait.

On a write, a bit selector indexed by the bit counter feeds the DRAM data-in pin for each column cycle. WE# goes low together with RAS#, well before the first CAS# fall, so the DRAM output stays in high impedance. On a read, the bit seen on the DRAM data-out pin during each column cycle is shifted into an assembly register. The byte is handed to the processor only after all eight bits are in.

A refresh timer requests a RAS-only refresh of the next row from an internal row counter. A refresh waits for any byte access in progress to finish, and it wins over a request that is pending in the same idle cycle. All strobe timings are parameters counted in clock cycles.

Top module: `dram_bitbyte_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, RAS#, CAS# and WE# are high, `cpu_wait` is low and `cpu_rdata` is 0.
- R2: When RAS# falls for a byte access, the DRAM address equals CPU address bits 14:6. When CAS# falls for bit k, the DRAM address equals {CPU address bits 5:0, k[2:0]}.
- R3: Each byte access makes exactly one RAS# fall and exactly eight CAS# falls, with k running 0,1,...,7 in that order.
- R4: On a write, the data-in pin at the CAS# fall for bit k equals write-data bit k, and WE# is low at every CAS# fall. On a read, WE# stays high. WE# never changes while RAS# stays low.
- R5: After a read, `cpu_rdata` bit k equals the DRAM output bit during column cycle k. `cpu_rdata` changes only in the cycle where `cpu_wait` falls after a read.
- R6: A `cpu_req` pulse seen while `cpu_wait` is low raises `cpu_wait` in the next cycle. `cpu_wait` stays high until the access ends, and it falls in the same cycle that RAS# rises. A `cpu_req` pulse while `cpu_wait` is high starts no access.
- R7: Each CAS# low phase lasts exactly T_CAS cycles. RAS# is high for more than T_RP cycles before each fall.
- R8: A refresh is a RAS# activation with no CAS# fall. Its address is {0, row counter}. The row counter starts at 0 and steps by one modulo 256 after each refresh.
- R9: The start of each refresh follows the previous one (or reset) by at most REF_INTERVAL plus one full byte-access length. This holds even when processor requests are issued back to back.
- R10: CAS# falls only while RAS# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-cycle access request strobe |
| cpu_we | input | 1 | 1 = write, 0 = read (sampled with cpu_req) |
| cpu_addr | input | 15 | Byte address (sampled with cpu_req) |
| cpu_wdata | input | 8 | Write byte (sampled with cpu_req) |
| cpu_rdata | output | 8 | Assembled read byte |
| cpu_wait | output | 1 | High while an accepted access is pending or running |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data bit into the DRAM |
| dram_dout | input | 1 | Data bit out of the DRAM |

## Verification
A due refresh and a pending processor request can both be present in the same idle cycle, and the arbiter must pick the refresh. The bench provokes this with bursts of writes in which each new request is issued right after `cpu_wait` falls. The request is then captured during precharge, alongside a refresh that became due during the previous byte. The outcome is judged in two ways. The gap between refresh starts must stay within the R9 bound, and every burst byte must read back intact.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,  // arbitration point
    ST_RCD,   // row open, waiting before first column
    ST_CSET,  // CAS high, column address and data set up
    ST_CLO,   // CAS low
    ST_PRE,   // RAS precharge
    ST_REF    // RAS-only refresh, RAS low
  } dbb_state_e;
endpackage

// File: rtl/dbb_refresh_timer.sv
module dbb_refresh_timer #(
  parameter int INTERVAL = 3000,
  parameter int ROW_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             due,
  output logic [ROW_W-1:0] row
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CW-1:0] tick;
  logic          wrap;

  assign wrap = (tick == CW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
      due  <= 1'b0;
      row  <= '0;
    end else begin
      tick <= wrap ? '0 : tick + 1'b1;
      if (wrap)     due <= 1'b1;
      else if (ack) due <= 1'b0;
      if (ack) row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/dbb_addr_mux.sv
module dbb_addr_mux #(
  parameter int DRAM_AW = 9,
  parameter int BSEL_W  = 3,
  parameter int CPU_AW  = 2 * DRAM_AW - BSEL_W
) (
  input  logic [CPU_AW-1:0]  byte_addr,
  input  logic [BSEL_W-1:0]  bit_idx,
  input  logic               pick_col,
  output logic [DRAM_AW-1:0] mux_addr
);
  localparam int LOW_W = DRAM_AW - BSEL_W;

  logic [DRAM_AW-1:0] row_half;
  logic [DRAM_AW-1:0] col_half;

  assign row_half = byte_addr[CPU_AW-1 -: DRAM_AW];
  assign col_half = {byte_addr[LOW_W-1:0], bit_idx};
  assign mux_addr = pick_col ? col_half : row_half;
endmodule

// File: rtl/dbb_bit_select.sv
module dbb_bit_select #(
  parameter int BSEL_W = 3,
  parameter int BYTE_W = 2 ** BSEL_W
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [BSEL_W-1:0] idx,
  output logic              bit_out
);
  logic [BYTE_W-1:0] hit;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
    assign hit[g] = byte_in[g] & (idx == BSEL_W'(g));
  end

  assign bit_out = |hit;
endmodule

// File: rtl/dram_bitbyte_ctrl.sv
module dram_bitbyte_ctrl
  import dbb_pkg::*;
#(
  parameter int DRAM_AW      = 9,
  parameter int BSEL_W       = 3,
  parameter int BYTE_W       = 2 ** BSEL_W,
  parameter int CPU_AW       = 2 * DRAM_AW - BSEL_W,
  parameter int REF_ROW_W    = 8,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 2,
  parameter int T_RP         = 2,
  parameter int T_RAS        = 3,
  parameter int REF_INTERVAL = 3000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [BYTE_W-1:0]  cpu_wdata,
  output logic [BYTE_W-1:0]  cpu_rdata,
  output logic               cpu_wait,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic               dram_ras_n,
  output logic               dram_cas_n,
  output logic               dram_we_n,
  output logic               dram_din,
  input  logic               dram_dout
);
  localparam int T_A   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int T_B   = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int T_C   = (T_A > T_B) ? T_A : T_B;
  localparam int T_MAX = (T_C > T_RAS) ? T_C : T_RAS;
  localparam int TCW   = $clog2(T_MAX + 1);
  localparam logic [BSEL_W-1:0] LAST_BIT = BSEL_W'(BYTE_W - 1);

  dbb_state_e          state;
  logic [TCW-1:0]      tcnt;
  logic [BSEL_W-1:0]   bit_idx;
  logic [BSEL_W-1:0]   nxt_idx;
  logic [CPU_AW-1:0]   lat_addr;
  logic [BYTE_W-1:0]   lat_wdata;
  logic                lat_we;
  logic [BYTE_W-2:0]   assem;
  logic                ref_due;
  logic                ref_ack;
  logic [REF_ROW_W-1:0] ref_row;
  logic [DRAM_AW-1:0]  row_addr;
  logic [DRAM_AW-1:0]  col_addr;
  logic                nxt_din;
  logic                tdone;

  assign tdone   = (tcnt == '0);
  assign nxt_idx = (state == ST_RCD) ? '0 : bit_idx + 1'b1;
  assign ref_ack = (state == ST_IDLE) && ref_due;

  dbb_refresh_timer #(
    .INTERVAL (REF_INTERVAL),
    .ROW_W    (REF_ROW_W)
  ) ref_i (
    .clk (clk),
    .rst (rst),
    .ack (ref_ack),
    .due (ref_due),
    .row (ref_row)
  );

  dbb_addr_mux #(
    .DRAM_AW (DRAM_AW),
    .BSEL_W  (BSEL_W),
    .CPU_AW  (CPU_AW)
  ) row_mux_i (
    .byte_addr (lat_addr),
    .bit_idx   (nxt_idx),
    .pick_col  (1'b0),
    .mux_addr  (row_addr)
  );

  dbb_addr_mux #(
    .DRAM_AW (DRAM_AW),
    .BSEL_W  (BSEL_W),
    .CPU_AW  (CPU_AW)
  ) col_mux_i (
    .byte_addr (lat_addr),
    .bit_idx   (nxt_idx),
    .pick_col  (1'b1),
    .mux_addr  (col_addr)
  );

  dbb_bit_select #(
    .BSEL_W (BSEL_W),
    .BYTE_W (BYTE_W)
  ) wsel_i (
    .byte_in (lat_wdata),
    .idx     (nxt_idx),
    .bit_out (nxt_din)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_PRE;
      tcnt       <= TCW'(T_RP - 1);
      bit_idx    <= '0;
      lat_addr   <= '0;
      lat_wdata  <= '0;
      lat_we     <= 1'b0;
      assem      <= '0;
      cpu_rdata  <= '0;
      cpu_wait   <= 1'b0;
      dram_addr  <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_din   <= 1'b0;
    end else begin
      if (cpu_req && !cpu_wait) begin
        lat_addr  <= cpu_addr;
        lat_wdata <= cpu_wdata;
        lat_we    <= cpu_we;
        cpu_wait  <= 1'b1;
      end

      unique case (state)
        ST_IDLE: begin
          if (ref_due) begin
            dram_addr  <= {{(DRAM_AW - REF_ROW_W){1'b0}}, ref_row};
            dram_ras_n <= 1'b0;
            tcnt       <= TCW'(T_RAS - 1);
            state      <= ST_REF;
          end else if (cpu_wait) begin
            dram_addr  <= row_addr;
            dram_ras_n <= 1'b0;
            dram_we_n  <= !lat_we;
            bit_idx    <= '0;
            tcnt       <= TCW'(T_RCD - 1);
            state      <= ST_RCD;
          end
        end
        ST_RCD: begin
          if (tdone) begin
            dram_addr <= col_addr;
            dram_din  <= nxt_din;
            tcnt      <= TCW'(T_CP - 1);
            state     <= ST_CSET;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        ST_CSET: begin
          if (tdone) begin
            dram_cas_n <= 1'b0;
            tcnt       <= TCW'(T_CAS - 1);
            state      <= ST_CLO;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        ST_CLO: begin
          if (tdone) begin
            dram_cas_n <= 1'b1;
            if (bit_idx == LAST_BIT) begin
              dram_ras_n <= 1'b1;
              dram_we_n  <= 1'b1;
              cpu_wait   <= 1'b0;
              if (!lat_we) cpu_rdata <= {dram_dout, assem};
              tcnt       <= TCW'(T_RP - 1);
              state      <= ST_PRE;
            end else begin
              assem     <= {dram_dout, assem[BYTE_W-2:1]};
              bit_idx   <= nxt_idx;
              dram_addr <= col_addr;
              dram_din  <= nxt_din;
              tcnt      <= TCW'(T_CP - 1);
              state     <= ST_CSET;
            end
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        ST_REF: begin
          if (tdone) begin
            dram_ras_n <= 1'b1;
            tcnt       <= TCW'(T_RP - 1);
            state      <= ST_PRE;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (tdone) state <= ST_IDLE;
          else       tcnt  <= tcnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbb_ctrl_chk.sv
module dbb_ctrl_chk #(
  parameter int BYTE_W = 8,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_wait,
  input logic [BYTE_W-1:0] cpu_rdata,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_we_n
);
  logic [7:0] cas_lo_cnt;
  logic [7:0] ras_hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_lo_cnt <= '0;
      ras_hi_cnt <= '0;
    end else begin
      cas_lo_cnt <= dram_cas_n ? 8'd0 : cas_lo_cnt + 8'd1;
      if (!dram_ras_n)             ras_hi_cnt <= 8'd0;
      else if (ras_hi_cnt != 8'hFF) ras_hi_cnt <= ras_hi_cnt + 8'd1;
    end
  end

  // R10
  cas_in_row_chk: assert property (@(posedge clk) disable iff (rst)
    dram_ras_n |-> dram_cas_n);

  // R7
  cas_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_cas_n) |-> (cas_lo_cnt == 8'(T_CAS)));

  // R7
  ras_prech_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> (ras_hi_cnt >= 8'(T_RP)));

  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dram_ras_n && $past(!dram_ras_n)) |-> $stable(dram_we_n));

  // R4
  cas_we_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_cas_n) |-> $stable(dram_we_n));

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(cpu_wait) |-> $stable(cpu_rdata));

  // R6
  wait_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_wait) |=> cpu_wait);

  // R6
  wait_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_wait) |-> $rose(dram_ras_n));
endmodule

bind dram_bitbyte_ctrl dbb_ctrl_chk #(
  .BYTE_W (BYTE_W),
  .T_CAS  (T_CAS),
  .T_RP   (T_RP)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cpu_req    (cpu_req),
  .cpu_wait   (cpu_wait),
  .cpu_rdata  (cpu_rdata),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n)
);

// File: tb/dram_bitbyte_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_bitbyte_ctrl_tb_top;
  localparam int T_RCD  = 2;
  localparam int T_CAS  = 2;
  localparam int T_CP   = 2;
  localparam int T_RP   = 2;
  localparam int T_RAS  = 3;
  localparam int REF_IV = 200;
  localparam int ACC_L  = 1 + T_RCD + 8 * (T_CP + T_CAS) + T_RP;
  localparam int GAP_MAX = REF_IV + ACC_L + 2;
  localparam int NVEC   = 13;

  // {write, address[14:0], data[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b1, 15'h0000, 8'hA5}, {1'b1, 15'h7FFF, 8'h5A}, {1'b1, 15'h003F, 8'hFF},
    {1'b1, 15'h0040, 8'h00}, {1'b1, 15'h2AAA, 8'h01}, {1'b1, 15'h1555, 8'h80},
    {1'b0, 15'h0000, 8'h00}, {1'b0, 15'h7FFF, 8'h00}, {1'b0, 15'h003F, 8'h00},
    {1'b0, 15'h0040, 8'h00}, {1'b0, 15'h2AAA, 8'h00}, {1'b0, 15'h1555, 8'h00},
    {1'b0, 15'h0123, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0;
  logic        cpu_we = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_wait;
  logic [8:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din;
  logic        dram_dout = 1'b0;

  always #2.5 clk = ~clk;

  dram_bitbyte_ctrl #(
    .T_RCD (T_RCD), .T_CAS (T_CAS), .T_CP (T_CP), .T_RP (T_RP),
    .T_RAS (T_RAS), .REF_INTERVAL (REF_IV)
  ) dut_i (
    .clk (clk), .rst (rst), .cpu_req (cpu_req), .cpu_we (cpu_we),
    .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
    .cpu_wait (cpu_wait), .dram_addr (dram_addr), .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n), .dram_we_n (dram_we_n), .dram_din (dram_din),
    .dram_dout (dram_dout)
  );

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string msg,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  // ---------------- DRAM model, sampled at falling clock edges ------------
  bit          mem [int];
  byte         shadow [int];
  logic        p_ras, p_cas, active;
  int          cyc, act_start, cas_start, last_ref, ncas;
  int          acc_cnt = 0, ref_cnt = 0;
  logic [7:0]  exp_ref;
  logic [8:0]  m_row, a_row;
  logic [8:0]  cols [8];
  logic        dins [8];
  logic        wes [8];
  int          a_ncas;

  always @(negedge clk) begin
    if (rst) begin
      p_ras = 1'b1; p_cas = 1'b1; active = 1'b0;
      cyc = 0; last_ref = 0; exp_ref = 8'd0; ncas = 0;
    end else begin
      cyc++;
      if (p_ras && !dram_ras_n) begin
        active = 1'b1; m_row = dram_addr; ncas = 0; act_start = cyc;
      end
      if (p_cas && !dram_cas_n) begin
        chk(!dram_ras_n, "R10 CAS fell while RAS high", dram_ras_n, 0);
        if (ncas < 8) begin
          cols[ncas] = dram_addr; dins[ncas] = dram_din; wes[ncas] = dram_we_n;
        end
        if (!dram_we_n) mem[{m_row, dram_addr}] = dram_din;
        dram_dout = mem.exists({m_row, dram_addr}) ? mem[{m_row, dram_addr}] : 1'b0;
        ncas++; cas_start = cyc;
      end
      if (!p_cas && dram_cas_n)
        chk(cyc - cas_start == T_CAS, "R7 CAS low width", cyc - cas_start, T_CAS);
      if (!p_ras && dram_ras_n && active) begin
        active = 1'b0;
        if (ncas == 0) begin
          chk(m_row == {1'b0, exp_ref}, "R8 refresh row", m_row, {1'b0, exp_ref});
          chk(act_start - last_ref <= GAP_MAX, "R9 refresh gap",
              act_start - last_ref, GAP_MAX);
          last_ref = act_start; exp_ref++; ref_cnt++;
        end else begin
          acc_cnt++; a_row = m_row; a_ncas = ncas;
        end
      end
      p_ras = dram_ras_n; p_cas = dram_cas_n;
    end
  end

  // ---------------- Access task ---------------------------------------------
  task automatic do_access(input bit we, input logic [14:0] addr, input logic [7:0] data,
                           input bit check_model, input bit inject);
    int guard;
    int acc0;
    logic [7:0] exp_rd;
    logic [7:0] rd_before;
    bit         cols_ok, din_ok, we_ok;
    @(negedge clk);
    acc0 = acc_cnt;
    rd_before = cpu_rdata;
    exp_rd = shadow.exists(int'(addr)) ? shadow[int'(addr)] : 8'h00;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = data;
    @(negedge clk);
    cpu_req = 1'b0;
    chk(cpu_wait, "R6 wait raised after request", cpu_wait, 1);
    guard = 0;
    while (cpu_wait && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (inject && guard == 3) begin
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 15'h1234; cpu_wdata = 8'hEE;
      end else begin
        cpu_req = 1'b0;
      end
    end
    cpu_req = 1'b0;
    chk(!cpu_wait, "R6 wait released", cpu_wait, 0);
    if (we) shadow[int'(addr)] = data;
    if (!we) chk(cpu_rdata == exp_rd, "R5 read byte", cpu_rdata, exp_rd);
    else     chk(cpu_rdata == rd_before, "R5 rdata unchanged by write", cpu_rdata, rd_before);
    if (check_model) begin
      @(negedge clk);
      chk(acc_cnt == acc0 + 1, "R3 one row activation per byte", acc_cnt - acc0, 1);
      chk(a_row == addr[14:6], "R2 row address", a_row, addr[14:6]);
      chk(a_ncas == 8, "R3 eight column cycles", a_ncas, 8);
      cols_ok = 1; din_ok = 1; we_ok = 1;
      for (int k = 0; k < 8; k++) begin
        if (cols[k] != {addr[5:0], 3'(k)}) cols_ok = 0;
        if (we && dins[k] != data[k]) din_ok = 0;
        if (wes[k] != !we) we_ok = 0;
      end
      chk(cols_ok, "R2 R3 column address order", cols[7], {addr[5:0], 3'd7});
      chk(din_ok, "R4 write data bits", dins[0], data[0]);
      chk(we_ok, "R4 WE level at CAS", wes[0], !we);
    end
  endtask

  // ---------------- Stimulus ------------------------------------------------
  initial begin
    int acc_snap;
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes high in reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
    chk(!cpu_wait && cpu_rdata == 8'h00, "R1 wait and rdata in reset",
        {cpu_wait, cpu_rdata}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && !cpu_wait, "R1 idle after reset",
        {dram_ras_n, dram_cas_n, cpu_wait}, 3'b110);

    for (int i = 0; i < NVEC; i++)
      do_access(VEC[i][23], VEC[i][22:8], VEC[i][7:0], 1'b1, 1'b0);

    // R6: request during an access is ignored
    do_access(1'b1, 15'h0400, 8'h3C, 1'b1, 1'b1);
    acc_snap = acc_cnt;
    repeat (60) @(negedge clk);
    chk(acc_cnt == acc_snap && !cpu_wait, "R6 request while waiting ignored",
        acc_cnt - acc_snap, 0);
    do_access(1'b0, 15'h1234, 8'h00, 1'b1, 1'b0);
    do_access(1'b0, 15'h0400, 8'h00, 1'b1, 1'b0);

    // R9: back-to-back writes put a refresh and a request in the same idle cycle
    for (int i = 0; i < 24; i++)
      do_access(1'b1, 15'(16'h0800 + i * 37), 8'(i * 29 + 3), 1'b0, 1'b0);
    for (int i = 0; i < 24; i += 5)
      do_access(1'b0, 15'(16'h0800 + i * 37), 8'h00, 1'b1, 1'b0);

    repeat (GAP_MAX) @(negedge clk);
    chk(ref_cnt > 0, "R8 refreshes issued", ref_cnt, 1);
    chk(cyc - last_ref <= GAP_MAX, "R9 refresh continues when idle", cyc - last_ref, GAP_MAX);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end
endmodule